// File: doc/BRIEF.md
# Microcontroller I/O Space Access Unit

This unit serves the CPU's accesses to a small 8-bit I/O register space. One request per cycle arrives as an operation code, an address, a bit index and write data. Port-style input/output requests name a 6-bit I/O address directly. Data-space load/store requests use the data-memory address, where the same I/O registers sit 0x20 higher. An extended window above them can only be reached by load/store. Single-bit set, clear and test requests work on the lower half of the I/O space only.

Inside the unit are a bank of general-purpose 8-bit registers and a status register. Its flags are raised by an event input port and cleared by writing a one to them. A bit set or clear touches only the named bit. So a bit operation on the status register clears exactly one flag and leaves the other pending flags alone. Read data and the bit-test result are combinational, so the CPU can use them in the same cycle for loads and skip decisions. A request outside its legal range is dropped and raises a one-cycle error pulse.

Default map (I/O addresses): status flags at 0x0C, general-purpose registers at 0x1C, 0x1D and 0x1E. There is one extended register at data address 0x60. Every other address is reserved.

Top module: `io_space_unit`

## Requirements
- R1: Port-style requests (op IN=1, OUT=2) with address 0x00..0x3F read or write the register at that I/O address. A write takes effect at the next rising clock edge.
- R2: Load/store requests (op LOAD=3, STORE=4) with data address 0x20..0x5F reach the register at I/O address (data address minus 0x20).
- R3: The extended register at data address 0x60 is read and written by load/store only. A port-style request with address 0x60 does not reach it.
- R4: Bit requests (op BSET=5, BCLR=6, BTEST=7) with an address above 0x1F change no register and return 0 on bit_val. The following cycle err_pulse is 1 for exactly one cycle.
- R5: BSET and BCLR on a general-purpose register change only the bit named by req_bit. All other bits keep their value.
- R6: Status flags occupy bits 3:0 of the status register. A byte write clears each flag whose write-data bit is 1 and leaves flags written with 0 unchanged. BSET clears only the named flag, and BCLR leaves the flags unchanged.
- R7: An event_set bit that is high in the same cycle as a clear of that flag leaves the flag set.
- R8: After a synchronous active-high reset, every register reads 0 and err_pulse is 0.
- R9: Status bits 7:4 are reserved and always read 0. Writes to reserved addresses (for example I/O 0x05) change no register and read back 0.
- R10: BTEST returns the addressed bit of the addressed register on bit_val in the same cycle as the request.
- R11: Port-style requests with an address above 0x3F write nothing, return rdata 0 and raise err_pulse for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | Operation: 0 idle, 1 IN, 2 OUT, 3 LOAD, 4 STORE, 5 BSET, 6 BCLR, 7 BTEST |
| req_addr | input | 8 | I/O address (IN/OUT/bit ops) or data address (LOAD/STORE) |
| req_bit | input | 3 | Bit index for BSET/BCLR/BTEST |
| wdata | input | 8 | Write data for OUT/STORE |
| event_set | input | 4 | Hardware events, each sets its status flag |
| rdata | output | 8 | Read data for IN/LOAD, else 0 |
| bit_val | output | 1 | Addressed bit for BTEST, else 0 |
| err_pulse | output | 1 | One-cycle pulse after an out-of-range request |

## Verification
The same registers are reached through both address maps: they are written through one map and read back through the other. This separates a correct 0x20 offset from an alias or a missing translation. Bit requests and port requests are sent to addresses whose low bits alias a live register (0x3C, 0x5C), so a missing range check shows up as a corrupted register rather than passing silently. On the status register, the flags are set first. Then zero writes, one-hot writes, single-bit sets and clears, and clears that collide with events are sent against them. Each pattern tells write-one-to-clear apart from plain writes and from read-modify-write behaviour, and shows which side wins when set and clear meet.

// File: rtl/io_space_pkg.sv
package io_space_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_IN    = 3'd1,
        OP_OUT   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4,
        OP_BSET  = 3'd5,
        OP_BCLR  = 3'd6,
        OP_BTEST = 3'd7
    } io_op_e;

    typedef struct packed {
        logic       io_hit;
        logic [5:0] io_idx;
        logic       ext_hit;
        logic [7:0] ext_addr;
        logic       illegal;
        logic       rd;
        logic       wr_byte;
        logic       bset;
        logic       bclr;
        logic       btest;
    } io_dec_s;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
    import io_space_pkg::*;
#(
    parameter int IO_OFFSET = 32,
    parameter int PORT_SPAN = 64,
    parameter int BIT_SPAN  = 32
) (
    input  io_op_e     op,
    input  logic [7:0] addr,
    output io_dec_s    dec
);
    localparam int EXT_START = IO_OFFSET + PORT_SPAN;

    always_comb begin
        dec = '0;
        unique case (op)
            OP_IN, OP_OUT: begin
                if (int'(addr) < PORT_SPAN) begin
                    dec.io_hit  = 1'b1;
                    dec.io_idx  = addr[5:0];
                    dec.rd      = (op == OP_IN);
                    dec.wr_byte = (op == OP_OUT);
                end else begin
                    dec.illegal = 1'b1;
                end
            end
            OP_LOAD, OP_STORE: begin
                dec.rd      = (op == OP_LOAD);
                dec.wr_byte = (op == OP_STORE);
                if (int'(addr) >= IO_OFFSET && int'(addr) < EXT_START) begin
                    dec.io_hit = 1'b1;
                    dec.io_idx = 6'(int'(addr) - IO_OFFSET);
                end else if (int'(addr) >= EXT_START) begin
                    dec.ext_hit  = 1'b1;
                    dec.ext_addr = addr;
                end
            end
            OP_BSET, OP_BCLR, OP_BTEST: begin
                if (int'(addr) < BIT_SPAN) begin
                    dec.io_hit = 1'b1;
                    dec.io_idx = addr[5:0];
                    dec.bset   = (op == OP_BSET);
                    dec.bclr   = (op == OP_BCLR);
                    dec.btest  = (op == OP_BTEST);
                end else begin
                    dec.illegal = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/io_flag_reg.sv
module io_flag_reg #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] evt_set,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags_q
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_st_s;

    flag_st_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_mask) | evt_set;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flags_q = st_q.flags;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((flags_q & $past(evt_set)) == $past(evt_set)));

    p_zero_clear_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_mask == '0 && evt_set == '0) |=> $stable(flags_q));
endmodule

// File: rtl/io_gp_bank.sv
module io_gp_bank #(
    parameter int NUM_REGS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_REGS-1:0]      sel,
    input  logic                     wr_byte,
    input  logic                     bset,
    input  logic                     bclr,
    input  logic [2:0]               bit_idx,
    input  logic [7:0]               wdata,
    output logic [NUM_REGS-1:0][7:0] regs_q
);
    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] regs;
    } bank_st_s;

    bank_st_s   st_d, st_q;
    logic [7:0] bit_mask;

    assign bit_mask = 8'd1 << bit_idx;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                if (wr_byte)   st_d.regs[i] = wdata;
                else if (bset) st_d.regs[i] = st_q.regs[i] | bit_mask;
                else if (bclr) st_d.regs[i] = st_q.regs[i] & ~bit_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign regs_q = st_q.regs;

    p_no_write_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |=> $stable(regs_q));

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: rtl/io_space_unit.sv
module io_space_unit
    import io_space_pkg::*;
#(
    parameter int FLAG_W    = 4,
    parameter int NUM_GP    = 3,
    parameter int FLAG_IO   = 12,
    parameter int GP_BASE   = 28,
    parameter int EXT_ADDR  = 96,
    parameter int IO_OFFSET = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        req_op,
    input  logic [7:0]        req_addr,
    input  logic [2:0]        req_bit,
    input  logic [7:0]        wdata,
    input  logic [FLAG_W-1:0] event_set,
    output logic [7:0]        rdata,
    output logic              bit_val,
    output logic              err_pulse
);
    localparam int NUM_REGS = NUM_GP + 1;
    localparam int RESV_W   = 8 - FLAG_W;

    typedef struct packed {
        logic err;
    } top_st_s;

    io_dec_s                  dec;
    logic [NUM_REGS-1:0]      sel;
    logic [NUM_REGS-1:0][7:0] regs;
    logic [FLAG_W-1:0]        flags;
    logic [FLAG_W-1:0]        clr_mask;
    logic                     flag_sel;
    logic [7:0]               sel_byte;
    top_st_s                  st_d, st_q;

    io_addr_decode #(.IO_OFFSET(IO_OFFSET), .PORT_SPAN(64), .BIT_SPAN(32)) u_dec (
        .op   (io_op_e'(req_op)),
        .addr (req_addr),
        .dec  (dec)
    );

    generate
        for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_sel
            assign sel[g] = dec.io_hit && (dec.io_idx == 6'(GP_BASE + g));
        end
    endgenerate
    assign sel[NUM_GP] = dec.ext_hit && (dec.ext_addr == 8'(EXT_ADDR));
    assign flag_sel    = dec.io_hit && (dec.io_idx == 6'(FLAG_IO));

    always_comb begin
        clr_mask = '0;
        if (flag_sel && dec.wr_byte) clr_mask = wdata[FLAG_W-1:0];
        else if (flag_sel && dec.bset) clr_mask = FLAG_W'(1) << req_bit;
    end

    io_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt_set  (event_set),
        .clr_mask (clr_mask),
        .flags_q  (flags)
    );

    io_gp_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr_byte (dec.wr_byte),
        .bset    (dec.bset),
        .bclr    (dec.bclr),
        .bit_idx (req_bit),
        .wdata   (wdata),
        .regs_q  (regs)
    );

    always_comb begin
        sel_byte = '0;
        if (flag_sel) sel_byte = {{RESV_W{1'b0}}, flags};
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) sel_byte = regs[i];
        end
    end

    assign rdata   = dec.rd ? sel_byte : 8'd0;
    assign bit_val = dec.btest ? sel_byte[req_bit] : 1'b0;

    always_comb begin
        st_d     = st_q;
        st_d.err = dec.illegal;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign err_pulse = st_q.err;

    p_err_follows_r4: assert property (@(posedge clk) disable iff (rst)
        dec.illegal |=> err_pulse);

    p_err_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        !dec.illegal |=> !err_pulse);

    p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        dec.illegal |-> (rdata == 8'd0 && !bit_val && sel == '0));

    p_resv_bits_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_sel && dec.rd) |-> (rdata[7:FLAG_W] == '0));
endmodule

// File: tb/test_io_space_unit.sv
module test_io_space_unit;
    import io_space_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req_op = 3'd0;
    logic [7:0] req_addr = 8'd0;
    logic [2:0] req_bit = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [3:0] event_set = 4'd0;
    logic [7:0] rdata;
    logic       bit_val;
    logic       err_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    io_space_unit i_io_space_unit (
        .clk       (clk),
        .rst       (rst),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_bit   (req_bit),
        .wdata     (wdata),
        .event_set (event_set),
        .rdata     (rdata),
        .bit_val   (bit_val),
        .err_pulse (err_pulse)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(io_op_e op, logic [7:0] a, logic [2:0] b,
                         logic [7:0] wd, logic [3:0] ev);
        @(negedge clk);
        req_op = op; req_addr = a; req_bit = b; wdata = wd; event_set = ev;
        #1;
    endtask

    task automatic idle();
        drive(OP_IDLE, 8'd0, 3'd0, 8'd0, 4'd0);
    endtask

    task automatic rd_in(logic [7:0] a, output logic [7:0] v);
        drive(OP_IN, a, 3'd0, 8'd0, 4'd0);
        v = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_in(8'h1C, v); chk("R8 gp0", v, 8'h00);
        chk("R8 err", {7'd0, err_pulse}, 8'h00);
        rd_in(8'h1E, v); chk("R8 gp2", v, 8'h00);
        rd_in(8'h0C, v); chk("R8 flags", v, 8'h00);
        drive(OP_LOAD, 8'h60, 3'd0, 8'd0, 4'd0); chk("R8 ext", rdata, 8'h00);
    endtask

    task automatic t_port();
        logic [7:0] v;
        drive(OP_OUT, 8'h1C, 3'd0, 8'hA5, 4'd0);
        drive(OP_OUT, 8'h1E, 3'd0, 8'h3C, 4'd0);
        rd_in(8'h1C, v); chk("R1 gp0", v, 8'hA5);
        rd_in(8'h1E, v); chk("R1 gp2", v, 8'h3C);
    endtask

    task automatic t_data();
        logic [7:0] v;
        drive(OP_STORE, 8'h3D, 3'd0, 8'h5A, 4'd0);
        rd_in(8'h1D, v); chk("R2 store->in", v, 8'h5A);
        drive(OP_LOAD, 8'h3C, 3'd0, 8'd0, 4'd0); chk("R2 load gp0", rdata, 8'hA5);
        drive(OP_LOAD, 8'h1C, 3'd0, 8'd0, 4'd0); chk("R2 below window", rdata, 8'h00);
    endtask

    task automatic t_ext();
        drive(OP_STORE, 8'h60, 3'd0, 8'h77, 4'd0);
        drive(OP_LOAD, 8'h60, 3'd0, 8'd0, 4'd0); chk("R3 ext load", rdata, 8'h77);
        drive(OP_IN, 8'h60, 3'd0, 8'd0, 4'd0); chk("R3 in ext", rdata, 8'h00);
        drive(OP_OUT, 8'h60, 3'd0, 8'h11, 4'd0);
        chk("R3 err after in", {7'd0, err_pulse}, 8'h01);
        drive(OP_LOAD, 8'h60, 3'd0, 8'd0, 4'd0); chk("R3 ext kept", rdata, 8'h77);
    endtask

    task automatic t_bitop();
        logic [7:0] v;
        drive(OP_BSET, 8'h1C, 3'd1, 8'hFF, 4'd0);
        drive(OP_BCLR, 8'h1C, 3'd7, 8'h00, 4'd0);
        rd_in(8'h1C, v); chk("R5 gp0 bits", v, 8'h27);
        drive(OP_BSET, 8'h1E, 3'd0, 8'h00, 4'd0);
        rd_in(8'h1E, v); chk("R5 gp2 bit0", v, 8'h3D);
    endtask

    task automatic t_test();
        drive(OP_BTEST, 8'h1C, 3'd0, 8'd0, 4'd0); chk("R10 bit0", {7'd0, bit_val}, 8'h01);
        drive(OP_BTEST, 8'h1C, 3'd3, 8'd0, 4'd0); chk("R10 bit3", {7'd0, bit_val}, 8'h00);
        drive(OP_BTEST, 8'h1D, 3'd6, 8'd0, 4'd0); chk("R10 gp1 bit6", {7'd0, bit_val}, 8'h01);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        drive(OP_IDLE, 8'd0, 3'd0, 8'd0, 4'b1011);
        rd_in(8'h0C, v); chk("R6 set", v, 8'h0B);
        drive(OP_OUT, 8'h0C, 3'd0, 8'h00, 4'd0);
        rd_in(8'h0C, v); chk("R6 zero write", v, 8'h0B);
        drive(OP_OUT, 8'h0C, 3'd0, 8'h01, 4'd0);
        rd_in(8'h0C, v); chk("R6 w1c bit0", v, 8'h0A);
        drive(OP_BSET, 8'h0C, 3'd3, 8'h00, 4'd0);
        rd_in(8'h0C, v); chk("R6 bset one flag", v, 8'h02);
        drive(OP_BCLR, 8'h0C, 3'd1, 8'h00, 4'd0);
        rd_in(8'h0C, v); chk("R6 bclr no effect", v, 8'h02);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        drive(OP_OUT, 8'h0C, 3'd0, 8'h02, 4'b0010);
        rd_in(8'h0C, v); chk("R7 set wins", v, 8'h02);
        drive(OP_OUT, 8'h0C, 3'd0, 8'h0F, 4'b0100);
        rd_in(8'h0C, v); chk("R7 mixed", v, 8'h04);
        drive(OP_OUT, 8'h0C, 3'd0, 8'h0F, 4'd0);
        rd_in(8'h0C, v); chk("R7 cleared", v, 8'h00);
    endtask

    task automatic t_resv();
        logic [7:0] v;
        drive(OP_IDLE, 8'd0, 3'd0, 8'd0, 4'hF);
        drive(OP_OUT, 8'h0C, 3'd0, 8'hF0, 4'd0);
        rd_in(8'h0C, v); chk("R9 resv bits", v, 8'h0F);
        drive(OP_OUT, 8'h05, 3'd0, 8'hFF, 4'd0);
        rd_in(8'h05, v); chk("R9 resv addr", v, 8'h00);
        rd_in(8'h1C, v); chk("R9 gp0 intact", v, 8'h27);
    endtask

    task automatic t_bad_bit();
        logic [7:0] v;
        drive(OP_BSET, 8'h3C, 3'd3, 8'd0, 4'd0);
        drive(OP_BTEST, 8'h3C, 3'd0, 8'd0, 4'd0);
        chk("R4 err", {7'd0, err_pulse}, 8'h01);
        chk("R4 btest zero", {7'd0, bit_val}, 8'h00);
        idle();
        chk("R4 err again", {7'd0, err_pulse}, 8'h01);
        idle();
        chk("R4 err drops", {7'd0, err_pulse}, 8'h00);
        rd_in(8'h1C, v); chk("R4 gp0 intact", v, 8'h27);
    endtask

    task automatic t_bad_port();
        logic [7:0] v;
        drive(OP_OUT, 8'h5C, 3'd0, 8'hFF, 4'd0);
        drive(OP_IN, 8'h5C, 3'd0, 8'd0, 4'd0);
        chk("R11 err", {7'd0, err_pulse}, 8'h01);
        chk("R11 read zero", rdata, 8'h00);
        rd_in(8'h1C, v); chk("R11 gp0 intact", v, 8'h27);
        chk("R11 err once more", {7'd0, err_pulse}, 8'h01);
        idle();
        chk("R11 err drops", {7'd0, err_pulse}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_port();
        t_data();
        t_ext();
        t_bitop();
        t_test();
        t_flags();
        t_prio();
        t_resv();
        t_bad_bit();
        t_bad_port();
        idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule